// File: doc/BRIEF.md
# Status Pin Controller

This block drives one open-drain status pin of a serially programmed frequency synthesizer. A 3-bit select code chooses what the pin reports. It can stay released, pull low while the loop is unlocked, or report the end of a frequency-counter measurement. It can also follow the level of one of two general-purpose I/O pins. Activity on the serial control bus overrides the select code. While chip-enable is high for a write transfer, the pin is released. While chip-enable is high for a read transfer, the pin carries the readback bit stream, which advances on falling edges of the serial clock.

The measurement indication is a small three-state tracker. A rising edge of the counter-enable bit arms it, and the pin is released while the measurement is pending. The counter's done strobe completes it, and the pin then pulls low. It stays low until the next rising edge of counter-enable or a reset. All inputs share one system clock. The serial clock is sampled as data and checked for edges. The pin drive is registered, so every change shows one clock after the inputs that cause it.

Top module: `stpin_ctrl`

## Requirements
- R1: During synchronous reset, and on the first clock edge after it, the pin is released (pin_oe = 0, pin_lvl = 1).
- R2: With chip_en low, select codes 000, 101, 110 and 111 keep the pin released, whatever the other inputs are.
- R3: With chip_en low and code 001, the pin pulls low (pin_oe = 1) while unlock_det is 1, and is released while it is 0.
- R4: With chip_en low and code 010, a 0-to-1 change of cnt_en makes the pin released (measurement pending). A cnt_done strobe while a measurement is pending makes the pin pull low. The pin stays low until the next 0-to-1 change of cnt_en or a reset.
- R5: A cnt_done strobe with no measurement pending, either after reset or after completion, does not change the tracker. If a cnt_en rising edge and cnt_done come in the same cycle, the rising edge wins and the measurement stays pending.
- R6: With chip_en low, code 011 selects I/O pin 0 and code 100 selects I/O pin 1. If that pin's gpio_is_out bit is 0, the status pin pulls low when the pin's gpio_lvl bit is 0 and is released when it is 1. If the gpio_is_out bit is 1, the status pin is released.
- R7: While chip_en is 1 and xfer_dir_out is 0 (write transfer), the pin is released, whatever the select code is.
- R8: While chip_en is 1 and xfer_dir_out is 1 (read transfer), the pin shows a held readback bit: it pulls low for 0 and is released for 1. The held bit takes rd_bit only on a clock where ser_clk is sampled low after being sampled high. Outside a read transfer, the held bit follows rd_bit on every clock.
- R9: The pin drive is registered with one clock of latency, and pin_lvl is 0 whenever pin_oe is 1 and 1 whenever pin_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_code | input | SEL_W (3) | Pin source select code |
| unlock_det | input | 1 | Loop unlock flag, 1 = unlocked |
| cnt_en | input | 1 | Counter-enable control bit; a rising edge starts a measurement |
| cnt_done | input | 1 | One-cycle strobe when the counter measurement finishes |
| gpio_lvl | input | GPIO_N (2) | Levels of the general-purpose I/O pins |
| gpio_is_out | input | GPIO_N (2) | Direction of each I/O pin, 1 = configured as output |
| chip_en | input | 1 | Serial bus chip-enable |
| xfer_dir_out | input | 1 | Transfer direction, 1 = read (readback), 0 = write |
| ser_clk | input | 1 | Serial bus clock, sampled by clk |
| rd_bit | input | 1 | Current readback bit from the serial shifter |
| pin_oe | output | 1 | Pin pull-down enable (1 = pin driven low) |
| pin_lvl | output | 1 | Pin level: 0 when driven, 1 when released |

## Verification
A behavioural reference model predicts the pin on every clock, so each scenario is checked cycle by cycle. Every select code is swept with unlock_det and the I/O levels set so that a mis-decoded code gives a visibly wrong pin. The measurement sequence includes a done strobe before arming, a simultaneous start and done, and a second start after completion. These separate a flag that sets on any strobe from one that needs arming, and a start-wins priority from a done-wins one. Serial read transfers toggle ser_clk with alternating readback bits, so updating on the wrong clock edge or ignoring the override shows up. A pseudo-random phase mixes all inputs to catch interactions between modes.

// File: rtl/stpin_pkg.sv
package stpin_pkg;

    // Pin drive seen at the pad: oe pulls the line low, lvl is the resulting level
    typedef struct packed {
        logic oe;
        logic lvl;
    } pin_drive_t;

    localparam pin_drive_t PIN_RELEASE  = '{oe: 1'b0, lvl: 1'b1};
    localparam pin_drive_t PIN_PULL_LOW = '{oe: 1'b1, lvl: 1'b0};

    // Measurement tracker states
    typedef enum logic [1:0] {
        MEAS_IDLE = 2'd0,
        MEAS_PEND = 2'd1,
        MEAS_DONE = 2'd2
    } meas_state_t;

    // Select code values (integers so the select width stays a parameter)
    localparam int CODE_UNLOCK    = 1;
    localparam int CODE_MEAS      = 2;
    localparam int CODE_GPIO_BASE = 3;

    // Open-drain follower: a low level pulls the pin, a high level releases it
    function automatic pin_drive_t od_follow(input logic level);
        return level ? PIN_RELEASE : PIN_PULL_LOW;
    endfunction

endpackage

// File: rtl/stpin_meas_track.sv
module stpin_meas_track
    import stpin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cnt_en,
    input  logic        cnt_done,
    output meas_state_t state
);

    logic cnt_en_q;
    logic start_edge;

    assign start_edge = cnt_en & ~cnt_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_en_q <= 1'b0;
            state    <= MEAS_IDLE;
        end else begin
            cnt_en_q <= cnt_en;
            if (start_edge) begin
                state <= MEAS_PEND;
            end else if (cnt_done && state == MEAS_PEND) begin
                state <= MEAS_DONE;
            end
        end
    end

    // R4
    arm_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cnt_en) |=> (state == MEAS_PEND));

    // R5
    stray_done_chk: assert property (@(posedge clk) disable iff (rst)
        (state == MEAS_IDLE && !cnt_en && cnt_done) |=> (state == MEAS_IDLE));

    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == MEAS_DONE && !cnt_en) |=> (state == MEAS_DONE));

endmodule

// File: rtl/stpin_rdbk_hold.sv
module stpin_rdbk_hold (
    input  logic clk,
    input  logic rst,
    input  logic xfer_out,
    input  logic ser_clk,
    input  logic rd_bit,
    output logic rd_q
);

    logic ser_q;
    logic ser_fall;

    assign ser_fall = ser_q & ~ser_clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_q <= 1'b0;
            rd_q  <= 1'b1;
        end else begin
            ser_q <= ser_clk;
            if (!xfer_out || ser_fall) begin
                rd_q <= rd_bit;
            end
        end
    end

    // R8
    hold_between_edges_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_out && ser_clk) |=> $stable(rd_q));

endmodule

// File: rtl/stpin_src_mux.sv
module stpin_src_mux
    import stpin_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int GPIO_N = 2
) (
    input  logic [SEL_W-1:0]  sel_code,
    input  logic              unlock_det,
    input  meas_state_t       meas_state,
    input  logic [GPIO_N-1:0] gpio_lvl,
    input  logic [GPIO_N-1:0] gpio_is_out,
    input  logic              chip_en,
    input  logic              xfer_out,
    input  logic              rd_q,
    output pin_drive_t        nxt
);

    pin_drive_t gpio_drv [GPIO_N];

    // Each I/O pin: released when configured as output, else open-drain follow
    for (genvar g = 0; g < GPIO_N; g++) begin : g_gpio
        assign gpio_drv[g] = gpio_is_out[g] ? PIN_RELEASE : od_follow(gpio_lvl[g]);
    end

    int sel_i;
    assign sel_i = int'(sel_code);

    always_comb begin
        nxt = PIN_RELEASE;
        if (chip_en) begin
            if (xfer_out) begin
                nxt = od_follow(rd_q);
            end
        end else if (sel_i == CODE_UNLOCK) begin
            if (unlock_det) nxt = PIN_PULL_LOW;
        end else if (sel_i == CODE_MEAS) begin
            if (meas_state == MEAS_DONE) nxt = PIN_PULL_LOW;
        end else begin
            for (int i = 0; i < GPIO_N; i++) begin
                if (sel_i == CODE_GPIO_BASE + i) nxt = gpio_drv[i];
            end
        end
    end

endmodule

// File: rtl/stpin_ctrl.sv
module stpin_ctrl
    import stpin_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int GPIO_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel_code,
    input  logic              unlock_det,
    input  logic              cnt_en,
    input  logic              cnt_done,
    input  logic [GPIO_N-1:0] gpio_lvl,
    input  logic [GPIO_N-1:0] gpio_is_out,
    input  logic              chip_en,
    input  logic              xfer_dir_out,
    input  logic              ser_clk,
    input  logic              rd_bit,
    output logic              pin_oe,
    output logic              pin_lvl
);

    localparam int CODE_SPAN = 1 << SEL_W;
    localparam int CODE_LAST = CODE_GPIO_BASE + GPIO_N - 1;

    meas_state_t meas_state;
    logic        xfer_out;
    logic        rd_q;
    pin_drive_t  nxt;
    pin_drive_t  drv_q;
    logic        rst_d;

    assign xfer_out = chip_en & xfer_dir_out;

    stpin_meas_track u_meas (
        .clk      (clk),
        .rst      (rst),
        .cnt_en   (cnt_en),
        .cnt_done (cnt_done),
        .state    (meas_state)
    );

    stpin_rdbk_hold u_rdbk (
        .clk      (clk),
        .rst      (rst),
        .xfer_out (xfer_out),
        .ser_clk  (ser_clk),
        .rd_bit   (rd_bit),
        .rd_q     (rd_q)
    );

    stpin_src_mux #(
        .SEL_W  (SEL_W),
        .GPIO_N (GPIO_N)
    ) u_mux (
        .sel_code    (sel_code),
        .unlock_det  (unlock_det),
        .meas_state  (meas_state),
        .gpio_lvl    (gpio_lvl),
        .gpio_is_out (gpio_is_out),
        .chip_en     (chip_en),
        .xfer_out    (xfer_out),
        .rd_q        (rd_q),
        .nxt         (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q <= PIN_RELEASE;
        end else begin
            drv_q <= nxt;
        end
    end

    assign pin_oe  = drv_q.oe;
    assign pin_lvl = drv_q.lvl;

    // Elaboration-time sanity of the code space
    initial begin
        code_space_chk: assert (CODE_LAST < CODE_SPAN);
    end

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            // R1
            reset_open_chk: assert (!pin_oe && pin_lvl);
        end
    end

    // R9
    level_coherent_chk: assert property (@(posedge clk) disable iff (rst)
        pin_oe != pin_lvl);

    // R7
    write_xfer_open_chk: assert property (@(posedge clk) disable iff (rst)
        (chip_en && !xfer_dir_out) |=> !pin_oe);

    // R3
    unlock_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!chip_en && int'(sel_code) == CODE_UNLOCK && unlock_det) |=> pin_oe);

    // R2
    idle_code_open_chk: assert property (@(posedge clk) disable iff (rst)
        (!chip_en && (int'(sel_code) == 0 || int'(sel_code) > CODE_LAST)) |=> !pin_oe);

endmodule

// File: tb/stpin_ctrl_tb_top.sv
module stpin_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel_code = 3'd0;
    logic       unlock_det = 1'b0;
    logic       cnt_en = 1'b0;
    logic       cnt_done = 1'b0;
    logic [1:0] gpio_lvl = 2'b00;
    logic [1:0] gpio_is_out = 2'b00;
    logic       chip_en = 1'b0;
    logic       xfer_dir_out = 1'b0;
    logic       ser_clk = 1'b0;
    logic       rd_bit = 1'b0;
    logic       pin_oe;
    logic       pin_lvl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 0;

    stpin_ctrl dut_i (
        .clk (clk), .rst (rst), .sel_code (sel_code), .unlock_det (unlock_det),
        .cnt_en (cnt_en), .cnt_done (cnt_done), .gpio_lvl (gpio_lvl),
        .gpio_is_out (gpio_is_out), .chip_en (chip_en), .xfer_dir_out (xfer_dir_out),
        .ser_clk (ser_clk), .rd_bit (rd_bit), .pin_oe (pin_oe), .pin_lvl (pin_lvl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int    m_meas  = 0;   // 0 idle, 1 pending, 2 complete
    int    m_cprev = 0;
    int    m_sprev = 0;
    int    m_rd    = 1;
    bit    exp_q[$];
    string tag_q[$];

    always @(posedge clk) begin
        bit    e;
        string t;
        e = 0;
        if (rst) begin
            t = "R1";
            m_meas = 0; m_cprev = 0; m_sprev = 0; m_rd = 1;
        end else begin
            if (chip_en && xfer_dir_out) begin
                t = "R8"; e = (m_rd == 0);
            end else if (chip_en) begin
                t = "R7";
            end else begin
                case (sel_code)
                    3'd1: begin t = "R3"; e = unlock_det; end
                    3'd2: begin t = "R4"; e = (m_meas == 2); end
                    3'd3: begin t = "R6"; e = !gpio_is_out[0] && !gpio_lvl[0]; end
                    3'd4: begin t = "R6"; e = !gpio_is_out[1] && !gpio_lvl[1]; end
                    default: t = "R2";
                endcase
            end
            if (cnt_en && m_cprev == 0) m_meas = 1;
            else if (cnt_done && m_meas == 1) m_meas = 2;
            m_cprev = cnt_en;
            if (!(chip_en && xfer_dir_out) || (m_sprev == 1 && !ser_clk)) m_rd = rd_bit;
            m_sprev = ser_clk;
        end
        exp_q.push_back(e);
        tag_q.push_back(t);
    end

    // Compare away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0 && !done_flag) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (pin_oe !== e) begin
                n_fail++;
                $display("FAIL %s: pin_oe=%0b expected %0b at %0t", t, pin_oe, e, $time);
            end
            n_tests++;
            if (pin_lvl !== !e) begin
                n_fail++;
                $display("FAIL R9: pin_lvl=%0b expected %0b at %0t", pin_lvl, !e, $time);
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string t, input logic got, input logic expv);
        n_tests++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", t, got, expv, $time);
        end
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done_flag) begin
            done_flag = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int lfsr;
        step(3);
        // R1 reset state
        chk("R1", pin_oe, 1'b0);
        chk("R1", pin_lvl, 1'b1);
        rst = 1'b0;
        step(1);
        chk("R1", pin_oe, 1'b0);

        // R2 idle codes with every other source active
        unlock_det = 1'b1; gpio_lvl = 2'b00;
        foreach (sel_code[i]) ;
        sel_code = 3'd0; step(3); chk("R2", pin_oe, 1'b0);
        sel_code = 3'd5; step(3); chk("R2", pin_oe, 1'b0);
        sel_code = 3'd6; step(3); chk("R2", pin_oe, 1'b0);
        sel_code = 3'd7; step(3); chk("R2", pin_oe, 1'b0);

        // R3 unlock code
        sel_code = 3'd1; step(2); chk("R3", pin_oe, 1'b1);
        unlock_det = 1'b0; step(2); chk("R3", pin_oe, 1'b0);
        unlock_det = 1'b1; step(1); unlock_det = 1'b0; step(3);

        // R4 / R5 measurement tracker
        sel_code = 3'd2;
        cnt_done = 1'b1; step(1); cnt_done = 1'b0; step(2);
        chk("R5", pin_oe, 1'b0);               // stray done ignored
        cnt_en = 1'b1; step(3); chk("R4", pin_oe, 1'b0);
        cnt_done = 1'b1; step(1); cnt_done = 1'b0; step(2);
        chk("R4", pin_oe, 1'b1);               // complete -> low
        cnt_done = 1'b1; step(1); cnt_done = 1'b0; step(3);
        chk("R5", pin_oe, 1'b1);               // extra done keeps low
        cnt_en = 1'b0; step(3); chk("R4", pin_oe, 1'b1); // falling edge keeps low
        cnt_en = 1'b1; cnt_done = 1'b1; step(1); cnt_done = 1'b0; step(2);
        chk("R5", pin_oe, 1'b0);               // start wins over same-cycle done
        cnt_done = 1'b1; step(1); cnt_done = 1'b0; step(2);
        chk("R4", pin_oe, 1'b1);
        cnt_en = 1'b0; step(1); cnt_en = 1'b1; step(2);
        chk("R4", pin_oe, 1'b0);               // new start releases
        cnt_en = 1'b0;

        // R6 I/O pin follow
        sel_code = 3'd3; gpio_lvl = 2'b10; gpio_is_out = 2'b00; step(2);
        chk("R6", pin_oe, 1'b1);
        gpio_lvl = 2'b01; step(2); chk("R6", pin_oe, 1'b0);
        sel_code = 3'd4; step(2); chk("R6", pin_oe, 1'b1);
        gpio_is_out = 2'b10; step(2); chk("R6", pin_oe, 1'b0);
        sel_code = 3'd3; gpio_lvl = 2'b00; gpio_is_out = 2'b01; step(2);
        chk("R6", pin_oe, 1'b0);
        gpio_is_out = 2'b00; step(2); chk("R6", pin_oe, 1'b1);

        // R7 write transfer overrides a pulling source
        chip_en = 1'b1; xfer_dir_out = 1'b0; step(2); chk("R7", pin_oe, 1'b0);
        chip_en = 1'b0; step(2); chk("R6", pin_oe, 1'b1);

        // R8 read transfer with serial clock
        rd_bit = 1'b0; step(1);
        chip_en = 1'b1; xfer_dir_out = 1'b1; step(2); chk("R8", pin_oe, 1'b1);
        for (int b = 0; b < 8; b++) begin
            ser_clk = 1'b1; rd_bit = b[0]; step(2);
            ser_clk = 1'b0; step(3);
        end
        rd_bit = 1'b0; step(2); chk("R8", pin_oe, 1'b0); // b=7 bit 1 held? held=1 -> released
        chip_en = 1'b0; xfer_dir_out = 1'b0; step(2);

        // Mixed pseudo-random phase
        lfsr = 32'h1ACE5;
        for (int c = 0; c < 600; c++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
            sel_code     = lfsr[2:0];
            unlock_det   = lfsr[3];
            cnt_en       = lfsr[4] & lfsr[5];
            cnt_done     = lfsr[6];
            gpio_lvl     = lfsr[8:7];
            gpio_is_out  = lfsr[10:9] & {lfsr[11], lfsr[11]};
            chip_en      = lfsr[12] & lfsr[13];
            xfer_dir_out = lfsr[14];
            ser_clk      = lfsr[15];
            rd_bit       = lfsr[16];
            if (c == 300) rst = 1'b1;
            if (c == 303) rst = 1'b0;
            step(1);
        end
        chip_en = 1'b0; rst = 1'b0;
        step(3);

        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule